// File: doc/BRIEF.md
# Parallel Configuration Readback Sequencer

This block pulls a requested number of bytes out of a target FPGA over its byte-wide parallel configuration port. It selects the device, drives the configuration clock through one full low-then-high cycle per byte, samples the 8-bit read bus once the high phase has run its course, and hands each byte to a valid/ready stream. It stalls the configuration clock whenever the stream consumer holds back. It keeps the write strobe in its read state throughout and never drives the data bus.

A readback starts with a one-cycle `start` pulse that carries the byte count. When the count is reached, the sequencer releases chip-select while the clock is still high. It then gives one further complete clock pulse so that the device registers the deselect. A one-cycle `done` pulse closes the operation. Each clock phase, and the select setup time, lasts `PHASE_CYC` system clocks.

Top module: `cfg_readback`

## Requirements
- R1: While reset is held and afterwards while idle, `selN` is 1, `cfgClk` is 1, `outValid` is 0, `done` is 0 and `busy` is 0.
- R2: `wrN` is 1 and `dataOe` is 0 in every cycle.
- R3: After `start`, `selN` goes to 0 with `cfgClk` at 1. This state lasts exactly `PHASE_CYC` cycles before the first low phase.
- R4: Every low phase of `cfgClk` lasts exactly `PHASE_CYC` cycles. A byte is sampled from `readData` at the end of the following high phase, `PHASE_CYC` cycles after the rising edge. Bytes leave on `outData` in device order.
- R5: A readback of N bytes produces exactly N rising edges of `cfgClk` while `selN` is 0 and exactly N stream transfers.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `cfgClk` hold their values into the next cycle.
- R7: At the end, `selN` rises while `cfgClk` is 1. It is followed by exactly one full low-then-high pulse of `cfgClk` with `selN` at 1.
- R8: `done` is high for exactly one cycle, after the trailing pulse's high phase. `busy` is 0 in the next cycle.
- R9: A `start` pulse while `busy` is 1 is ignored. It does not change the byte count of the readback in progress.
- R10: A byte count of 0 produces no selected clock edges and no stream transfers. It still runs the select, deselect and trailing pulse and ends with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a readback |
| byteCount | input | CNT_W | Number of bytes to read, sampled with `start` |
| readData | input | DATA_W | Configuration port read bus |
| outReady | input | 1 | Stream consumer ready |
| selN | output | 1 | Device chip-select, active low |
| cfgClk | output | 1 | Configuration clock to the device |
| wrN | output | 1 | Write strobe, held in read state (1) |
| dataOe | output | 1 | Data bus drive enable, held at 0 |
| outValid | output | 1 | Stream byte valid |
| outData | output | DATA_W | Stream byte |
| busy | output | 1 | Readback in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several kinds of internal fault show up at the ports. A sequencer that loses its place gives an extra or a missing selected clock edge, and the byte stream then moves off the device's data order from the next byte onward. A phase timer that is off by one shows up at the next clock transition as a wrong phase length. A stall that fails to hold the clock or the held byte shows up in the very next cycle of a back-pressured transfer. A faulty end sequence shows up within one phase as a deselect while the clock is low, a missing or duplicated trailing pulse, or a `done` that lasts longer than one cycle.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_LOW,
    S_HIGH,
    S_WAIT,
    S_DESEL,
    S_TLOW,
    S_THIGH,
    S_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldTarget;
    logic clrTimer;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/cfgrb_datapath.sv
module cfgrb_datapath
  import cfgrb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int PHASE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [DATA_W-1:0] readData,
  input  logic              outReady,
  output logic              timerDone,
  output logic              countHit,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int TMR_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PHASE_CYC - 1);

  logic [TMR_W-1:0] phaseTmr;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] byteCnt;

  assign timerDone = (phaseTmr == TMR_LAST);
  assign countHit  = (byteCnt == target);

  // phase timer: cleared on every state change, saturates at the last cycle
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrTimer) begin
      phaseTmr <= '0;
    end else if (!timerDone) begin
      phaseTmr <= phaseTmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target  <= '0;
      byteCnt <= '0;
    end else if (stb.ldTarget) begin
      target  <= startCount;
      byteCnt <= '0;
    end else if (stb.capture) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  // single-entry output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (stb.capture) begin
      outValid <= 1'b1;
      outData  <= readData;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

  p_hold_data_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_count_bound_r5 : assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= target);

endmodule

// File: rtl/cfgrb_control.sv
module cfgrb_control
  import cfgrb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      timerDone,
  input  logic      countHit,
  input  logic      outValid,
  input  logic      outReady,
  output dpStrobe_t stb,
  output logic      selN,
  output logic      cfgClk,
  output logic      busy,
  output logic      done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    stb.ldTarget = 1'b0;
    stb.capture  = 1'b0;
    unique case (state)
      S_IDLE:  if (start) begin
                 stb.ldTarget = 1'b1;
                 nextState    = S_SETUP;
               end
      S_SETUP: if (timerDone) nextState = countHit ? S_DESEL : S_LOW;
      S_LOW:   if (timerDone) nextState = S_HIGH;
      S_HIGH:  if (timerDone) begin
                 stb.capture = 1'b1;
                 nextState   = S_WAIT;
               end
      S_WAIT:  if (outValid && outReady) nextState = countHit ? S_DESEL : S_LOW;
      S_DESEL: if (timerDone) nextState = S_TLOW;
      S_TLOW:  if (timerDone) nextState = S_THIGH;
      S_THIGH: if (timerDone) nextState = S_FIN;
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
    stb.clrTimer = (nextState != state);
  end

  assign selN   = (state == S_IDLE) || (state == S_DESEL) || (state == S_TLOW) ||
                  (state == S_THIGH) || (state == S_FIN);
  assign cfgClk = !((state == S_LOW) || (state == S_TLOW));
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);

  p_stall_clk_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(cfgClk));

  p_desel_clk_high_r7 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(selN) |-> cfgClk);

  p_done_pulse_r8 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_no_capture_idle_r1 : assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stb.capture);

endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfgrb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int PHASE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [DATA_W-1:0] readData,
  input  logic              outReady,
  output logic              selN,
  output logic              cfgClk,
  output logic              wrN,
  output logic              dataOe,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              busy,
  output logic              done
);

  dpStrobe_t stb;
  logic      timerDone;
  logic      countHit;

  assign wrN    = 1'b1;
  assign dataOe = 1'b0;

  cfgrb_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerDone (timerDone),
    .countHit  (countHit),
    .outValid  (outValid),
    .outReady  (outReady),
    .stb       (stb),
    .selN      (selN),
    .cfgClk    (cfgClk),
    .busy      (busy),
    .done      (done)
  );

  cfgrb_datapath #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .PHASE_CYC (PHASE_CYC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .startCount (byteCount),
    .readData   (readData),
    .outReady   (outReady),
    .timerDone  (timerDone),
    .countHit   (countHit),
    .outValid   (outValid),
    .outData    (outData)
  );

endmodule

// File: tb/cfg_readback_tb_top.sv
`timescale 1ns/100ps
module cfg_readback_tb_top;

  localparam int PH = 3;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [CW-1:0] byteCount = '0;
  logic [7:0]  readData;
  logic        outReady = 1'b1;
  logic        selN, cfgClk, wrN, dataOe, outValid, busy, done;
  logic [7:0]  outData;

  always #2.5 clk = ~clk;

  cfg_readback #(.DATA_W(8), .CNT_W(CW), .PHASE_CYC(PH)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .readData(readData), .outReady(outReady), .selN(selN), .cfgClk(cfgClk),
    .wrN(wrN), .dataOe(dataOe), .outValid(outValid), .outData(outData),
    .busy(busy), .done(done)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    return 8'(j * 29 + 7);
  endfunction

  // device model: new byte appears after each selected rising edge
  int devEdge = 0;
  int trailCnt = 0;
  always @(posedge cfgClk) begin
    if (!selN) devEdge <= devEdge + 1;
    else       trailCnt <= trailCnt + 1;
  end
  assign readData = pat(devEdge);

  // ready generator
  bit readyMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = readyMode ? lfsr[0] : 1'b1;
  end

  // scoreboard
  logic [7:0] expQ[$];
  int popped = 0;
  bit prevStall = 1'b0;
  logic prevClk = 1'b1;
  logic [7:0] prevData = '0;
  int setupLen = 0;
  bit seenLow = 1'b0;
  int lowLen = 0;
  logic prevSel = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (!(wrN === 1'b1 && dataOe === 1'b0)) check(0, "R2 wrN/dataOe", {wrN, dataOe}, 2);
      if (prevStall) begin
        check(cfgClk === prevClk && outData === prevData && outValid === 1'b1,
              "R6 stall hold", int'(outData), int'(prevData));
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(0, "R5 extra byte", int'(outData), -1);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(outData === e, "R4 byte order", int'(outData), int'(e));
        end
        popped++;
      end
      // R3 select setup
      if (selN) begin
        setupLen = 0; seenLow = 1'b0;
      end else if (!seenLow) begin
        if (cfgClk) setupLen++;
        else begin
          check(setupLen == PH, "R3 select setup length", setupLen, PH);
          seenLow = 1'b1;
        end
      end
      // R4 low phase width
      if (!cfgClk) lowLen++;
      else if (lowLen > 0) begin
        check(lowLen == PH, "R4 low phase length", lowLen, PH);
        lowLen = 0;
      end
      // R7 deselect while clock high
      if (selN && !prevSel) check(cfgClk === 1'b1, "R7 deselect clock level", cfgClk, 1);
    end
    prevSel   = selN;
    prevStall = outValid && !outReady;
    prevClk   = cfgClk;
    prevData  = outData;
  end

  task automatic runRead(input int n, input bit stall, input bit inject);
    int base, trail0, pop0, cyc;
    readyMode = stall;
    base = devEdge; trail0 = trailCnt; pop0 = popped;
    for (int k = 0; k < n; k++) expQ.push_back(pat(base + 1 + k));
    @(posedge clk); #1; start = 1'b1; byteCount = CW'(n);
    @(posedge clk); #1; start = 1'b0; byteCount = '0;
    if (inject) begin
      repeat (3) @(posedge clk);
      #1; start = 1'b1; byteCount = CW'(n + 5);
      @(posedge clk); #1; start = 1'b0;
    end
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!done && cyc < 20000);
    check(done === 1'b1, "R8 done seen", done, 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8 done one cycle", {done, busy}, 0);
    check(devEdge - base == n, inject ? "R9 edges after ignored start" : "R5 selected edges",
          devEdge - base, n);
    check(popped - pop0 == n, n == 0 ? "R10 no transfers" : "R5 transfers", popped - pop0, n);
    check(trailCnt - trail0 == 1, "R7 trailing pulse count", trailCnt - trail0, 1);
    check(expQ.size() == 0, "R4 queue drained", expQ.size(), 0);
    readyMode = 1'b0;
    repeat (2) @(negedge clk);
    check(selN === 1'b1 && cfgClk === 1'b1 && !busy, "R1 idle after run", {selN, cfgClk, busy}, 6);
  endtask

  task automatic runAll;
    repeat (3) @(negedge clk);
    check(selN === 1'b1 && cfgClk === 1'b1 && outValid === 1'b0 && done === 1'b0 && busy === 1'b0,
          "R1 reset state", {selN, cfgClk, outValid, done, busy}, 24);
    @(posedge clk); #1; rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && selN === 1'b1, "R1 idle", {busy, selN}, 1);
    runRead(1, 1'b0, 1'b0);
    runRead(6, 1'b0, 1'b0);
    runRead(12, 1'b1, 1'b0);   // R6 back-pressure
    runRead(5, 1'b0, 1'b1);    // R9 start while busy
    runRead(0, 1'b0, 1'b0);    // R10 zero count
    runRead(9, 1'b1, 1'b0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule